// File: doc/BRIEF.md
# SDRAM Command-Phase Address Multiplexer

This block drives the address pins of an SDRAM array from a 32-bit system bus address. The array is a 64-bit port of eight byte-wide devices. Each device has four internal banks, 12 row lines and 9 column lines. Banks are interleaved: the two bank-select bits sit in the system address directly above the row field. System address bits are numbered 0 (most significant) to 31. Bits 0–5 are the high start address, 6–7 the bank, 8–19 the row, 20–28 the column and 29–31 the byte lane. The same numbering is used for the device address field. In the Verilog vectors, numbered bit k is vector index 31-k.

A requester presents an address, a command code, an auto-precharge / all-banks flag and a gap setting. The block latches them on acceptance. A read or write request is expanded into an ACTIVATE cycle, a programmable run of NOP cycles and then the column command. ACTIVATE, precharge and auto-refresh requests are issued as a single command. For each command the block drives the multiplexed device address, the bank-select lines inside that field, and a dedicated A10 pin. During ACTIVATE the A10 pin carries a row bit. During column, refresh and precharge commands it carries the flag.

Command codes on `req_cmd` and `sd_cmd`: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 auto-refresh, 5 precharge. Codes 6 and 7 are treated as NOP.

Top module: `sdram_amux_top`

## Requirements
- R1: During ACTIVATE, `sd_addr` carries the bank (system bits 6–7, vector [25:24]) on device bits 15–16 (vector [16:15]) and the row (system bits 8–19, vector [23:12]) on device bits 17–28 (vector [14:3]). Every other bit is 0.
- R2: During ACTIVATE, `sd_a10` equals system bit 9 (vector index 22).
- R3: During READ or WRITE, `sd_addr` carries the bank on vector [16:15], the column (system bits 20–28, vector [11:3]) on vector [11:3] and the flag on device bit 18 (vector index 13). Every other bit is 0, and `sd_a10` equals the flag.
- R4: During precharge, `sd_addr` carries only the bank on vector [16:15], and `sd_a10` equals the flag (all banks).
- R5: During auto-refresh, `sd_addr` is 0 and `sd_a10` equals the flag.
- R6: A READ or WRITE request accepted at clock edge k produces ACTIVATE for one cycle after edge k. It is followed by N NOP cycles and then the column command (code 2 or 3). N is `gap_cycles` sampled at acceptance, and a value of 0 is treated as 1.
- R7: `seq_done` is high for exactly one cycle. For a read or write this is the column-command cycle. For a single-command request it is the cycle of that command. At all other times it is low.
- R8: `req_ready` is low from the cycle after acceptance until the done cycle ends, and high again on the next cycle. Changes to `req_addr`, `req_ap` or `gap_cycles` while busy have no effect on the commands issued.
- R9: A request with code 0, 6 or 7 is ignored: no command is issued and `req_ready` stays high.
- R10: Out of reset, and in every NOP cycle, `sd_cmd` is 0, `sd_addr` is 0 and `sd_a10` is 0. After reset `req_ready` is 1 and `seq_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | System byte address |
| req_cmd | input | 3 | Requested command code |
| req_ap | input | 1 | Auto-precharge / all-banks flag |
| gap_cycles | input | 3 | NOP cycles between ACTIVATE and column command (0 means 1) |
| sd_cmd | output | 3 | Command issued this cycle |
| sd_addr | output | 32 | Multiplexed device address field, bank bits included |
| sd_a10 | output | 1 | Dedicated row-bit / auto-precharge pin |
| seq_done | output | 1 | Request completes this cycle |

## Verification
The bench builds the block with its default geometry: 2 bank bits, 12 row bits, 9 column bits, 3 lane bits and a 3-bit gap counter. This puts the A10 row bit at system vector index 22 and the flag at device vector index 13, so both are reached by ordinary addresses. The 3-bit gap setting makes every legal NOP run, from 1 to 7, reachable, as well as the 0-to-1 clamp. Random addresses with all-ones and alternating patterns are used, so every bank, row and column field is checked against its own slot.

// File: rtl/sdram_amux_pkg.sv
package sdram_amux_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_REF = 3'd4,
        CMD_PRE = 3'd5
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_GAP  = 3'd2,
        ST_COL  = 3'd3,
        ST_ONE  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int COL_W      = 9,
    parameter int LANE_W     = 3,
    parameter int AP_ROW_BIT = 10
) (
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              flag,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              pin_a10
);
    // Field positions in the system address (vector indices, LSB = 0)
    localparam int COL_LSB      = LANE_W;
    localparam int ROW_LSB      = COL_LSB + COL_W;
    localparam int BANK_LSB     = ROW_LSB + ROW_W;
    // Field positions on the device address field
    localparam int OUT_ROW_LSB  = LANE_W;
    localparam int OUT_COL_LSB  = LANE_W;
    localparam int OUT_BANK_LSB = OUT_ROW_LSB + ROW_W;
    localparam int OUT_AP_BIT   = OUT_ROW_LSB + AP_ROW_BIT;

    logic [BANK_W-1:0] bank_f;
    logic [ROW_W-1:0]  row_f;
    logic [COL_W-1:0]  col_f;

    always_comb begin
        bank_f   = sys_addr[BANK_LSB +: BANK_W];
        row_f    = sys_addr[ROW_LSB +: ROW_W];
        col_f    = sys_addr[COL_LSB +: COL_W];
        dev_addr = '0;
        pin_a10  = 1'b0;
        case (cmd)
            CMD_ACT: begin
                dev_addr[OUT_BANK_LSB +: BANK_W] = bank_f;
                dev_addr[OUT_ROW_LSB +: ROW_W]   = row_f;
                pin_a10                          = row_f[AP_ROW_BIT];
            end
            CMD_RD, CMD_WR: begin
                dev_addr[OUT_BANK_LSB +: BANK_W] = bank_f;
                dev_addr[OUT_COL_LSB +: COL_W]   = col_f;
                dev_addr[OUT_AP_BIT]             = flag;
                pin_a10                          = flag;
            end
            CMD_PRE: begin
                dev_addr[OUT_BANK_LSB +: BANK_W] = bank_f;
                pin_a10                          = flag;
            end
            CMD_REF: begin
                pin_a10 = flag;
            end
            default: begin
                dev_addr = '0;
                pin_a10  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_cmd,
    input  logic              req_ap,
    input  logic [DLY_W-1:0]  gap_cfg,
    output logic [2:0]        cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              flag_q,
    output logic              done_q
);
    typedef struct packed {
        seq_state_e        st;
        logic [DLY_W-1:0]  cnt;
        logic [DLY_W-1:0]  gap;
        logic [ADDR_W-1:0] addr;
        logic              flag;
        logic [2:0]        col;
        logic [2:0]        cmd;
        logic              rdy;
        logic              done;
    } seq_t;

    localparam logic [DLY_W-1:0] GAP_MIN = DLY_W'(1);

    seq_t r_d, r_q;
    logic take;

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.done = 1'b0;
        take     = req_valid && r_q.rdy;
        case (r_q.st)
            ST_IDLE: begin
                if (take) begin
                    case (req_cmd)
                        CMD_RD, CMD_WR: begin
                            r_d.st   = ST_ACT;
                            r_d.cmd  = CMD_ACT;
                            r_d.col  = req_cmd;
                            r_d.addr = req_addr;
                            r_d.flag = req_ap;
                            r_d.gap  = (gap_cfg == '0) ? GAP_MIN : gap_cfg;
                            r_d.rdy  = 1'b0;
                        end
                        CMD_ACT, CMD_REF, CMD_PRE: begin
                            r_d.st   = ST_ONE;
                            r_d.cmd  = req_cmd;
                            r_d.addr = req_addr;
                            r_d.flag = req_ap;
                            r_d.done = 1'b1;
                            r_d.rdy  = 1'b0;
                        end
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_ACT: begin
                r_d.st  = ST_GAP;
                r_d.cnt = r_q.gap;
            end
            ST_GAP: begin
                if (r_q.cnt <= GAP_MIN) begin
                    r_d.st   = ST_COL;
                    r_d.cmd  = r_q.col;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - GAP_MIN;
                end
            end
            ST_COL, ST_ONE: begin
                r_d.st  = ST_IDLE;
                r_d.rdy = 1'b1;
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.rdy = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.rdy <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.rdy;
    assign cmd_q     = r_q.cmd;
    assign addr_q    = r_q.addr;
    assign flag_q    = r_q.flag;
    assign done_q    = r_q.done;

    // R6: an ACTIVATE is always followed by a NOP cycle
    a_r6_act_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cmd == CMD_ACT |=> r_q.cmd == CMD_NOP);

    // R7: done only on a cycle that issues a command, and never two in a row
    a_r7_done_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.cmd != CMD_NOP) && (r_q.cmd != CMD_ACT || r_q.st == ST_ONE));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R8: latched request held while busy; ready returns after done
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.rdy && !r_d.rdy |=> $stable(r_q.addr) && $stable(r_q.flag));
    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> r_q.rdy);

endmodule

// File: rtl/sdram_amux_top.sv
module sdram_amux_top
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int COL_W      = 9,
    parameter int LANE_W     = 3,
    parameter int AP_ROW_BIT = 10,
    parameter int DLY_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_cmd,
    input  logic              req_ap,
    input  logic [DLY_W-1:0]  gap_cycles,
    output logic [2:0]        sd_cmd,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_a10,
    output logic              seq_done
);
    localparam int USED_TOP = LANE_W + ROW_W + BANK_W;
    localparam int AP_OUT   = LANE_W + AP_ROW_BIT;

    logic [2:0]        cmd_w;
    logic [ADDR_W-1:0] addr_w;
    logic              flag_w;

    sdram_cmd_seq #(
        .ADDR_W (ADDR_W),
        .DLY_W  (DLY_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_cmd   (req_cmd),
        .req_ap    (req_ap),
        .gap_cfg   (gap_cycles),
        .cmd_q     (cmd_w),
        .addr_q    (addr_w),
        .flag_q    (flag_w),
        .done_q    (seq_done)
    );

    sdram_addr_map #(
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .LANE_W     (LANE_W),
        .AP_ROW_BIT (AP_ROW_BIT)
    ) u_map (
        .cmd      (cmd_w),
        .sys_addr (addr_w),
        .flag     (flag_w),
        .dev_addr (sd_addr),
        .pin_a10  (sd_a10)
    );

    assign sd_cmd = cmd_w;

    // R1: device bits above the bank slot are never driven
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sd_addr[ADDR_W-1:USED_TOP] == '0);

    // R2: on ACTIVATE the A10 pin mirrors the row bit in the same device slot
    a_r2_a10_row: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_ACT |-> sd_a10 == sd_addr[AP_OUT]);

    // R3: on a column command the flag slot and the A10 pin agree
    a_r3_ap_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> sd_a10 == sd_addr[AP_OUT]);

    // R5: refresh drives no address
    a_r5_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_REF |-> sd_addr == '0);

    // R10: NOP cycles drive no address and no A10
    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_NOP |-> sd_addr == '0 && !sd_a10);

endmodule

// File: tb/test_sdram_amux_top.sv
`timescale 1ns/1ps
module test_sdram_amux_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_cmd = '0;
    logic        req_ap = 1'b0;
    logic [2:0]  gap_cycles = 3'd1;
    logic [2:0]  sd_cmd;
    logic [31:0] sd_addr;
    logic        sd_a10;
    logic        seq_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdram_amux_top i_sdram_amux_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_cmd    (req_cmd),
        .req_ap     (req_ap),
        .gap_cycles (gap_cycles),
        .sd_cmd     (sd_cmd),
        .sd_addr    (sd_addr),
        .sd_a10     (sd_a10),
        .seq_done   (seq_done)
    );

    function automatic logic [31:0] exp_act(input logic [31:0] a);
        logic [31:0] o = '0;
        o[16:15] = a[25:24];
        o[14:3]  = a[23:12];
        return o;
    endfunction

    function automatic logic [31:0] exp_col(input logic [31:0] a, input logic f);
        logic [31:0] o = '0;
        o[16:15] = a[25:24];
        o[11:3]  = a[11:3];
        o[13]    = f;
        return o;
    endfunction

    function automatic logic [31:0] exp_pre(input logic [31:0] a);
        logic [31:0] o = '0;
        o[16:15] = a[25:24];
        return o;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_nop(input string req);
        chk({req, " cmd"},   64'(sd_cmd),   64'd0);
        chk({req, " addr"},  64'(sd_addr),  64'd0);
        chk({req, " a10"},   64'(sd_a10),   64'd0);
        chk({req, " done"},  64'(seq_done), 64'd0);
    endtask

    // read or write: ACT, N NOPs, column command
    task automatic run_rw(input logic [2:0] c, input logic [31:0] a, input logic f, input logic [2:0] g);
        int n = (g == 3'd0) ? 1 : int'(g);
        @(negedge clk);
        chk("R8 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_ap = f; gap_cycles = g;
        @(negedge clk);
        req_valid = 1'b0; req_addr = $urandom; req_ap = ~f; gap_cycles = 3'($urandom);
        chk("R6 act cmd",  64'(sd_cmd),    64'd1);
        chk("R1 act addr", 64'(sd_addr),   64'(exp_act(a)));
        chk("R2 act a10",  64'(sd_a10),    64'(a[22]));
        chk("R7 no done on act", 64'(seq_done), 64'd0);
        chk("R8 ready low", 64'(req_ready), 64'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_nop("R10 gap");
            chk("R8 ready low in gap", 64'(req_ready), 64'd0);
        end
        @(negedge clk);
        chk("R6 col cmd",  64'(sd_cmd),   64'(c));
        chk("R3 col addr", 64'(sd_addr),  64'(exp_col(a, f)));
        chk("R3 col a10",  64'(sd_a10),   64'(f));
        chk("R7 done col", 64'(seq_done), 64'd1);
        chk("R8 ready low at done", 64'(req_ready), 64'd0);
        @(negedge clk);
        check_nop("R10 after col");
        chk("R8 ready back", 64'(req_ready), 64'd1);
    endtask

    task automatic run_one(input logic [2:0] c, input logic [31:0] a, input logic f);
        logic [31:0] ea;
        logic ef;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_ap = f;
        @(negedge clk);
        req_valid = 1'b0; req_addr = $urandom;
        case (c)
            3'd1:    begin ea = exp_act(a); ef = a[22]; end
            3'd4:    begin ea = '0;         ef = f;     end
            default: begin ea = exp_pre(a); ef = f;     end
        endcase
        if (c == 3'd4) begin
            chk("R5 ref addr", 64'(sd_addr), 64'(ea));
            chk("R5 ref a10",  64'(sd_a10),  64'(ef));
        end else if (c == 3'd5) begin
            chk("R4 pre addr", 64'(sd_addr), 64'(ea));
            chk("R4 pre a10",  64'(sd_a10),  64'(ef));
        end else begin
            chk("R1 act-only addr", 64'(sd_addr), 64'(ea));
            chk("R2 act-only a10",  64'(sd_a10),  64'(ef));
        end
        chk("R7 single cmd", 64'(sd_cmd),   64'(c));
        chk("R7 single done", 64'(seq_done), 64'd1);
        chk("R8 single busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        check_nop("R10 after single");
        chk("R8 single ready", 64'(req_ready), 64'd1);
    endtask

    task automatic run_ignored(input logic [2:0] c, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_ap = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_nop("R9 ignored");
        chk("R9 ready stays", 64'(req_ready), 64'd1);
        @(negedge clk);
        check_nop("R9 ignored later");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_nop("R10 reset");
        chk("R10 reset ready", 64'(req_ready), 64'd1);

        // directed corners
        run_rw(3'd2, 32'hFFFF_FFFF, 1'b1, 3'd1);
        run_rw(3'd3, 32'h0000_0000, 1'b0, 3'd7);
        run_rw(3'd2, 32'h5555_5555, 1'b1, 3'd0);
        run_rw(3'd3, 32'hAAAA_AAAA, 1'b0, 3'd3);
        run_rw(3'd2, 32'h0040_0000, 1'b0, 3'd2);
        run_one(3'd4, 32'hFFFF_FFFF, 1'b1);
        run_one(3'd4, 32'h1234_5678, 1'b0);
        run_one(3'd5, 32'hFFFF_FFFF, 1'b1);
        run_one(3'd5, 32'h0100_0000, 1'b0);
        run_one(3'd1, 32'h00C0_0000, 1'b0);
        run_ignored(3'd0, 32'hFFFF_FFFF);
        run_ignored(3'd6, 32'h1357_9BDF);
        run_ignored(3'd7, 32'h2468_ACE0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [2:0]  c = 3'($urandom_range(0, 7));
            logic [31:0] a = $urandom;
            logic        f = 1'($urandom);
            logic [2:0]  g = 3'($urandom);
            if (c == 3'd2 || c == 3'd3)      run_rw(c, a, f, g);
            else if (c == 3'd0 || c > 3'd5)  run_ignored(c, a);
            else                             run_one(c, a, f);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule